// File: doc/BRIEF.md
# Rising-Edge Dead-Band Generator for a Complementary Gate Pair

This block takes a single pulse-width-modulated control level and produces two gate-drive levels for a high-side and a low-side power switch. Each leg holds back the turn-on of its gate by a programmable number of clock cycles and turns the gate off on the next clock edge. The same hold-off applied to the true and to the inverted control level opens a dead band of equal width around both transitions. The two switches are therefore never commanded on at the same time.

Each leg has a saturating down-counter. The counter is reloaded from the delay input on every clock edge that sees the leg's level low. It counts down while the level stays high. The gate goes high when the counter is zero and stays high until the level drops. A high pulse no longer than the programmed delay produces no gate pulse at all. The programmed delay must therefore stay below the shortest on-time and off-time the modulator produces.

After reset a leg refuses to drive until it has seen its level low at least once. A level that is already high when reset is released cannot skip the dead band. The delay width is a parameter of at least eight bits, checked when the design is elaborated.

Top module: `gate_deadband_pair`

## Requirements
- R1: During reset both gate outputs are low. After reset is released, a gate stays low until its leg level has been sampled low on at least one clock edge.
- R2: The leg level of `hi_gate_o` is `pwm_i`; the leg level of `lo_gate_o` is the inverse of `pwm_i`. A gate is low in the cycle after any clock edge that samples its leg level low.
- R3: Let D be the value of `dly_i` at the last clock edge that sampled a leg's level low. The gate rises on the (D+1)-th consecutive clock edge that samples the level high. It then stays high for as long as the level stays high.
- R4: With D = 0 the gate rises on the first clock edge that samples the level high, which is one register of latency, the same as the falling edge.
- R5: A high run of N sampled edges with N <= D produces no gate pulse. A run with N > D produces exactly N - D high cycles.
- R6: A change of `dly_i` while a leg level is high does not alter the delay of that leg's current high run.
- R7: The counter saturates at zero. Holding a level high far beyond the largest delay (all ones in `dly_i`) keeps the gate continuously high, with no second hold-off.
- R8: `hi_gate_o` and `lo_gate_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; one period is the delay resolution |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Modulated control level, high means high-side on |
| dly_i | input | CNT_W | Turn-on hold-off in clock cycles, captured while a level is low |
| hi_gate_o | output | 1 | High-side gate drive, delayed rising edge of `pwm_i` |
| lo_gate_o | output | 1 | Low-side gate drive, delayed rising edge of inverted `pwm_i` |

## Verification
The bench aims at the edges of the hold-off arithmetic.

- A zero delay checks for an off-by-one: a design with that error would add a spurious cycle or turn on before the register.
- High runs of exactly D and D+1 cycles check the boundary of pulse suppression: a wrong design would either emit a one-cycle sliver or drop a legitimate pulse.
- A level held high for hundreds of cycles at the all-ones delay checks saturation: a wrapping counter would make the gate blink off after the wrap.
- Changing `dly_i` mid-pulse checks that the delay is captured while the level is low: a design that samples it live would shorten the current hold-off.
- Releasing reset with the level already high checks the arming rule: an unarmed leg would turn on without any dead band.

// File: rtl/dtp_pkg.sv
package dtp_pkg;

   // Smallest supported width of the delay count.
   localparam int unsigned MIN_CNT_W = 8;

   // Legs in a complementary pair: index 0 follows the level, index 1 its inverse.
   localparam int unsigned NUM_LEGS  = 2;
   localparam int unsigned LEG_HI    = 0;
   localparam int unsigned LEG_LO    = 1;

   // Per-leg control state.
   typedef enum logic [1:0] {
      LEG_BLOCKED  = 2'd0,  // after reset, level not yet seen low
      LEG_LOADED   = 2'd1,  // level low, counter holds the fresh delay
      LEG_COUNTING = 2'd2,  // level high, counter running down
      LEG_DRIVING  = 2'd3   // level high, hold-off expired, gate on
   } leg_state_e;

endpackage

// File: rtl/rise_delay_leg.sv
module rise_delay_leg
   import dtp_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_i,
   input  logic [CNT_W-1:0] dly_i,
   output logic             gate_o
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   generate
      if (CNT_W < MIN_CNT_W) begin : g_bad_width
         $error("rise_delay_leg: CNT_W below minimum width");
      end
   endgenerate

   leg_state_e       state_q, state_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic             gate_q, gate_n;
   logic             cnt_done;

   assign cnt_done = (cnt_q == CNT_ZERO);

   always_comb begin
      state_n = state_q;
      cnt_n   = cnt_q;
      gate_n  = gate_q;
      if (!lvl_i) begin
         // low level: rearm, reload and force the gate off
         state_n = LEG_LOADED;
         cnt_n   = dly_i;
         gate_n  = 1'b0;
      end else begin
         unique case (state_q)
            LEG_BLOCKED: begin
               gate_n = 1'b0;
            end
            LEG_LOADED, LEG_COUNTING: begin
               if (cnt_done) begin
                  state_n = LEG_DRIVING;
                  gate_n  = 1'b1;
               end else begin
                  state_n = LEG_COUNTING;
                  cnt_n   = cnt_q - CNT_ONE;
                  gate_n  = 1'b0;
               end
            end
            LEG_DRIVING: begin
               gate_n = 1'b1;
            end
            default: begin
               state_n = LEG_BLOCKED;
               gate_n  = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LEG_BLOCKED;
         cnt_q   <= CNT_ZERO;
         gate_q  <= 1'b0;
      end else begin
         state_q <= state_n;
         cnt_q   <= cnt_n;
         gate_q  <= gate_n;
      end
   end

   assign gate_o = gate_q;

   // R1: an unarmed leg never drives
   a_r1_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LEG_BLOCKED) |-> !gate_o);

   // R2: a low level turns the gate off on the next edge
   a_r2_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_i |=> !gate_o);

   // R3: turn-on only after a high sample with the counter exhausted
   a_r3_rise_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o) |-> ($past(lvl_i) && $past(cnt_q == CNT_ZERO)));

   // R3: once on, the gate holds while the level stays high
   a_r3_hold_until_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_o && lvl_i) |=> gate_o);

   // R7: counter sticks at zero while the level stays high
   a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_i && cnt_done && (state_q != LEG_BLOCKED)) |=> (cnt_q == CNT_ZERO));

endmodule

// File: rtl/gate_deadband_pair.sv
module gate_deadband_pair
   import dtp_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_i,
   input  logic [CNT_W-1:0] dly_i,
   output logic             hi_gate_o,
   output logic             lo_gate_o
);

   generate
      if (CNT_W < MIN_CNT_W) begin : g_bad_width
         $error("gate_deadband_pair: CNT_W below minimum width");
      end
   endgenerate

   logic [NUM_LEGS-1:0] leg_lvl;
   logic [NUM_LEGS-1:0] leg_gate;

   generate
      for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
         if (g == LEG_HI) begin : g_true
            assign leg_lvl[g] = pwm_i;
         end else begin : g_inv
            assign leg_lvl[g] = ~pwm_i;
         end

         rise_delay_leg #(
            .CNT_W (CNT_W)
         ) leg_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (leg_lvl[g]),
            .dly_i  (dly_i),
            .gate_o (leg_gate[g])
         );
      end
   endgenerate

   assign hi_gate_o = leg_gate[LEG_HI];
   assign lo_gate_o = leg_gate[LEG_LO];

   // R8: the complementary gates never overlap
   a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_gate_o && lo_gate_o));

   // R2: high side follows a low control level off
   a_r2_hi_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_i |=> !hi_gate_o);

   // R2: low side follows a high control level off
   a_r2_lo_fall: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_i |=> !lo_gate_o);

endmodule

// File: tb/gate_deadband_pair_tb_top.sv
module gate_deadband_pair_tb_top;

   localparam int unsigned CNT_W = 8;
   localparam int          WATCHDOG_NS = 900000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pwm = 1'b0;
   logic [CNT_W-1:0] dly = '0;
   logic             hi_gate, lo_gate;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // bench reference state, one entry per leg (0 high side, 1 low side)
   bit armed [2];
   int run   [2];
   int dlast [2];

   always #2.5 clk = ~clk;

   gate_deadband_pair #(.CNT_W(CNT_W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwm_i     (pwm),
      .dly_i     (dly),
      .hi_gate_o (hi_gate),
      .lo_gate_o (lo_gate)
   );

   // expected gate after an edge that samples level lvl with delay d
   function automatic bit ref_gate(input int leg, input bit lvl, input int d);
      if (!lvl) begin
         armed[leg] = 1'b1;
         dlast[leg] = d;
         run[leg]   = 0;
         return 1'b0;
      end
      if (run[leg] < 1000000) run[leg] = run[leg] + 1;
      return armed[leg] && (run[leg] >= dlast[leg] + 1);
   endfunction

   task automatic check(input string tag, input string what, input bit got, input bit exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s %s at %0t: got %0b expected %0b", tag, what, $time, got, exp);
      end
   endtask

   // apply one cycle of stimulus and check both gates after the edge
   task automatic step(input bit p, input int d, input string tag);
      bit eh, el;
      @(negedge clk);
      pwm = p;
      dly = CNT_W'(d);
      @(posedge clk);
      #1;
      eh = ref_gate(0, p, d);
      el = ref_gate(1, !p, d);
      check(tag, "hi_gate", hi_gate, eh);
      check(tag, "lo_gate", lo_gate, el);
      check("R8", "overlap", hi_gate & lo_gate, 1'b0);
   endtask

   task automatic segment(input bit p, input int len, input int d, input string tag);
      for (int i = 0; i < len; i++) step(p, d, tag);
   endtask

   task automatic do_reset(input bit p, input int d);
      @(negedge clk);
      rst_n = 1'b0;
      pwm = p;
      dly = CNT_W'(d);
      for (int l = 0; l < 2; l++) begin
         armed[l] = 1'b0;
         run[l]   = 0;
         dlast[l] = 0;
      end
      @(negedge clk);
      @(negedge clk);
      // R1: both gates low while reset is held
      check("R1", "hi_gate in reset", hi_gate, 1'b0);
      check("R1", "lo_gate in reset", lo_gate, 1'b0);
      rst_n = 1'b1;
   endtask

   initial begin
      #(WATCHDOG_NS);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired at %0t: got running expected finished", $time);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1bad5eed));

      // R1: release reset with the control level already high
      do_reset(1'b1, 3);
      segment(1'b1, 300, 3, "R1");
      segment(1'b0, 20, 3, "R1");

      // R3: nominal hold-off of ten cycles, both transitions
      for (int k = 0; k < 4; k++) begin
         segment(1'b1, 30, 10, "R3");
         segment(1'b0, 30, 10, "R3");
      end

      // R4: zero delay
      for (int k = 0; k < 3; k++) begin
         segment(1'b1, 5, 0, "R4");
         segment(1'b0, 5, 0, "R4");
      end
      segment(1'b1, 1, 0, "R4");
      segment(1'b0, 1, 0, "R4");

      // R5: runs of exactly D and D+1 for both legs
      segment(1'b0, 8, 5, "R5");
      segment(1'b1, 5, 5, "R5");
      segment(1'b0, 5, 5, "R5");
      segment(1'b1, 6, 5, "R5");
      segment(1'b0, 6, 5, "R5");
      segment(1'b1, 2, 5, "R5");

      // R6: delay captured while low, changed in mid pulse
      segment(1'b0, 10, 20, "R6");
      segment(1'b1, 40, 3, "R6");
      segment(1'b0, 40, 3, "R6");
      segment(1'b1, 10, 30, "R6");

      // R7: largest delay, long hold
      segment(1'b0, 5, 255, "R7");
      segment(1'b1, 700, 255, "R7");
      segment(1'b0, 700, 255, "R7");
      segment(1'b1, 5, 255, "R7");

      // R2: every fall path via random mix; R3 and R8 across random patterns
      for (int k = 0; k < 400; k++) begin
         int d, nh, nl;
         d  = int'($urandom_range(0, 40));
         nh = int'($urandom_range(1, 60));
         nl = int'($urandom_range(1, 60));
         segment(1'b1, nh, d, "R2");
         segment(1'b0, nl, int'($urandom_range(0, 40)), "R3");
      end

      // R1: reset again in the middle of activity, level low at release
      do_reset(1'b0, 4);
      segment(1'b0, 3, 4, "R1");
      segment(1'b1, 12, 4, "R1");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule